// File: doc/BRIEF.md
# Register-Transfer Microoperation Datapath

This block is a small register file of general-purpose registers with an operation unit. All of them share one clock. Each cycle a control word arrives. It names a microoperation, a first and a second source register, one destination register, an immediate byte and a shift amount. The selected result is written into the destination register on the next rising clock edge. The write goes through that register's load enable; the clock itself is never gated. Registers that are not addressed keep their value through the multiplexer in front of their D inputs.

A controller drives the control word. In the default build there are four 8-bit registers at indices 0 to 3, used as accumulator, base, counter and data register. Every register is visible on a flat output bus, so neighbouring logic and the bench can observe the results directly. A synchronous clear input zeroes every register and takes priority over any write in the same cycle. An active-low asynchronous reset brings the block to the same all-zero state.

Top module: `rt_datapath`

## Requirements
- R1: While `rst_n` is low, every register reads zero on `regs`.
- R2: When `clr` is high at a rising edge, every register is zero after that edge, even if `op` requests a write in the same cycle.
- R3: Op code 0x0 writes `imm` into register `dst`.
- R4: Op code 0x1 copies register `src_a` into register `dst`.
- R5: Op code 0x2 writes A+B and op code 0x3 writes A−B, both modulo 2^W, where A is register `src_a` and B is register `src_b`.
- R6: Op codes 0x4, 0x5 and 0x6 write A AND B, A OR B and A XOR B. Op code 0x7 writes NOT A.
- R7: Op code 0x8 writes A shifted left by `shamt`, and op code 0x9 writes A shifted right by `shamt`. `shamt` ranges from 0 to W−1, and vacated bit positions are filled with zeros.
- R8: Op code 0xA writes a concatenation. The upper half of the result is the W/2-bit field of A that starts at bit `shamt`. The lower half is the W/2-bit field of B that starts at bit `imm[log2(W)-1:0]`. Bit positions above the MSB read as zero.
- R9: On any edge without `clr`, every register other than `dst` keeps its value.
- R10: Sources are read before the edge, so when `dst` equals a source register, the operation uses that register's old value.
- R11: Op codes 0xB to 0xF write no register.
- R12: Register i appears on `regs[i*W +: W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all registers |
| op | input | 4 | Microoperation code |
| src_a | input | log2(NREG) | First source register index |
| src_b | input | log2(NREG) | Second source register index |
| dst | input | log2(NREG) | Destination register index |
| imm | input | W | Immediate byte; its low bits also select the B field for the concatenation |
| shamt | input | log2(W) | Shift amount and start bit of the A field |
| regs | output | NREG*W | Contents of all registers |

## Verification
The bench builds the default configuration: four registers of 8 bits. In this configuration every op code, including the five unused ones, can be applied once for each of the 256 values of the first operand. Because the bench rotates the register indices and steps through all eight shift amounts in the same pass, every field start and shift distance is covered. It also covers each combination where the destination equals a source, so that the old-value rule is exercised. The worked byte examples, and a clear issued together with a write, are checked on their own.

// File: rtl/rt_datapath.sv
module rt_datapath #(
  parameter int W = 8,
  parameter int NREG = 4,
  localparam int SELW = $clog2(NREG),
  localparam int SHW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [3:0]        op,
  input  logic [SELW-1:0]   src_a,
  input  logic [SELW-1:0]   src_b,
  input  logic [SELW-1:0]   dst,
  input  logic [W-1:0]      imm,
  input  logic [SHW-1:0]    shamt,
  output logic [NREG*W-1:0] regs
);
  localparam int NIB = W / 2;

  logic [W-1:0] q [NREG];
  logic [W-1:0] a, b, a_fld, b_fld, res;
  logic         valid;

  assign a     = q[src_a];
  assign b     = q[src_b];
  assign a_fld = a >> shamt;
  assign b_fld = b >> imm[SHW-1:0];

  always_comb begin
    valid = 1'b1;
    res   = '0;
    case (op)
      4'h0: res = imm;
      4'h1: res = a;
      4'h2: res = a + b;
      4'h3: res = a - b;
      4'h4: res = a & b;
      4'h5: res = a | b;
      4'h6: res = a ^ b;
      4'h7: res = ~a;
      4'h8: res = a << shamt;
      4'h9: res = a >> shamt;
      4'hA: res = {a_fld[NIB-1:0], b_fld[NIB-1:0]};
      default: valid = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic ld;
    assign ld = valid && (dst == SELW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[i] <= '0;
      else if (clr)  q[i] <= '0;
      else if (ld)   q[i] <= res;
    end
    assign regs[i*W +: W] = q[i];
  end
endmodule

// File: rtl/rt_datapath_chk.sv
module rt_datapath_chk #(
  parameter int W = 8,
  parameter int NREG = 4,
  localparam int SELW = $clog2(NREG),
  localparam int SHW = $clog2(W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic [3:0]        op,
  input logic [SELW-1:0]   src_a,
  input logic [SELW-1:0]   src_b,
  input logic [SELW-1:0]   dst,
  input logic [W-1:0]      imm,
  input logic [SHW-1:0]    shamt,
  input logic [NREG*W-1:0] regs
);
  logic [W-1:0] r [NREG];
  for (genvar i = 0; i < NREG; i++) begin : g_unpack
    assign r[i] = regs[i*W +: W];
  end

  logic [W-1:0] va, vb, vsum;
  assign va   = r[src_a];
  assign vb   = r[src_b];
  assign vsum = va + vb;

  always_comb if (!rst_n) assert_reset_zero_R1: assert (regs == '0);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> regs == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op == 4'h0) |=> r[$past(dst)] == $past(imm));

  assert_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op == 4'h1) |=> r[$past(dst)] == $past(va));

  assert_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op == 4'h2) |=> r[$past(dst)] == $past(vsum));

  assert_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op > 4'hA) |=> $stable(regs));

  for (genvar j = 0; j < NREG; j++) begin : g_hold
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && dst != SELW'(j)) |=> $stable(r[j]));
  end
endmodule

bind rt_datapath rt_datapath_chk #(.W(W), .NREG(NREG)) u_chk (.*);

// File: tb/test_rt_datapath.sv
module test_rt_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NREG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [3:0]  op = 4'hF;
  logic [1:0]  src_a = '0, src_b = '0, dst = '0;
  logic [7:0]  imm = '0;
  logic [2:0]  shamt = '0;
  logic [31:0] regs;

  int tests = 0;
  int fails = 0;
  logic [7:0] m [NREG];

  rt_datapath #(.W(W), .NREG(NREG)) i_rt_datapath (
    .clk(clk), .rst_n(rst_n), .clr(clr), .op(op), .src_a(src_a),
    .src_b(src_b), .dst(dst), .imm(imm), .shamt(shamt), .regs(regs));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] calc(input logic [3:0] o, input logic [7:0] a,
      input logic [7:0] b, input logic [7:0] im, input logic [2:0] s);
    int ai = a, bi = b;
    case (o)
      4'h0: return im;
      4'h1: return a;
      4'h2: return 8'((ai + bi) % 256);
      4'h3: return 8'((ai - bi + 256) % 256);
      4'h4: return a & b;
      4'h5: return a | b;
      4'h6: return a ^ b;
      4'h7: return 8'(255 - ai);
      4'h8: return 8'((ai * (1 << s)) % 256);
      4'h9: return 8'(ai / (1 << s));
      default: return 8'(((ai / (1 << s)) % 16) * 16 + (bi / (1 << im[2:0])) % 16);
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'h0: return "R3";
      4'h1: return "R4";
      4'h2, 4'h3: return "R5";
      4'h4, 4'h5, 4'h6, 4'h7: return "R6";
      4'h8, 4'h9: return "R7";
      4'hA: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req_dst, input logic [1:0] d);
    for (int j = 0; j < NREG; j++)
      check((j == d) ? req_dst : "R9", regs[j*8 +: 8], m[j]);
  endtask

  task automatic step(input logic [3:0] o, input logic [1:0] ra, input logic [1:0] rb,
      input logic [1:0] rd, input logic [7:0] im, input logic [2:0] s, input string req);
    logic [7:0] nv;
    @(negedge clk);
    op = o; src_a = ra; src_b = rb; dst = rd; imm = im; shamt = s;
    nv = calc(o, m[ra], m[rb], im, s);
    @(negedge clk);
    op = 4'hF;
    if (o <= 4'hA) m[rd] = nv;
    check_all(req, rd);
  endtask

  initial begin
    for (int j = 0; j < NREG; j++) m[j] = '0;
    #(CLK_PERIOD * 3);
    for (int j = 0; j < NREG; j++) check("R1", regs[j*8 +: 8], 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // worked byte examples
    step(4'h0, 0, 0, 0, 8'd12, 0, "R3");
    step(4'h0, 0, 0, 1, 8'd18, 0, "R3");
    step(4'h2, 0, 1, 2, 0, 0, "R5");
    check("R5", regs[16 +: 8], 8'b0001_1110);
    step(4'h3, 1, 0, 3, 0, 0, "R5");
    check("R5", regs[24 +: 8], 8'b0000_0110);
    step(4'h8, 0, 0, 2, 0, 2, "R7");
    check("R7", regs[16 +: 8], 8'b0011_0000);
    step(4'h7, 0, 0, 3, 0, 0, "R6");
    check("R6", regs[24 +: 8], 8'b1111_0011);
    step(4'h0, 0, 0, 1, 8'd20, 0, "R3");
    step(4'hA, 0, 1, 1, 8'd4, 2, "R8");
    check("R8", regs[8 +: 8], 8'b0011_0001);
    check("R12", regs, {m[3], m[2], m[1], m[0]});

    // sweep: every op against all 256 first-operand values
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 256; i++) begin
        logic [1:0] ra, rb, rd;
        string req;
        ra = 2'(i);
        rb = 2'(i + 1 + (i / 4) % 3);
        rd = (i % 7 == 0) ? ra : 2'(i + 2);
        step(4'h0, 0, 0, rb, 8'((i * 73 + 41) % 256), 0, "R3");
        step(4'h0, 0, 0, ra, 8'(i), 0, "R3");
        req = (rd == ra && o >= 1 && o <= 10) ? "R10" : tag_of(4'(o));
        step(4'(o), ra, rb, rd, 8'((i * 151 + 7) % 256), 3'(i), req);
      end
    end

    // clear wins over a simultaneous write
    step(4'h0, 0, 0, 2, 8'hA5, 0, "R3");
    @(negedge clk);
    clr = 1'b1; op = 4'h0; dst = 2'd2; imm = 8'h5A;
    @(negedge clk);
    clr = 1'b0; op = 4'hF;
    for (int j = 0; j < NREG; j++) begin
      m[j] = '0;
      check("R2", regs[j*8 +: 8], 8'h00);
    end
    step(4'h0, 0, 0, 3, 8'h3C, 0, "R3");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule